// File: doc/BRIEF.md
# SPI Master Transfer-Mode Sequencer

This block is a single-chip-select SPI master run through a small register port. Software loads bytes for transmission by writing the data register, which places them in a transmit FIFO. It then writes the transfer register with a 4-bit mode and two frame counts, and the block runs the bus. Depending on the mode, the block drives a write phase, a read phase and an optional one-frame dummy phase, in one of ten fixed orders. Received bytes land in a receive FIFO, and software drains it by reading the data register.

The serial side uses SPI mode 0 with 8-bit frames sent MSB first. The half-period of SCLK is taken from a divider register. When the transmit FIFO runs dry in a write phase, or the receive FIFO fills in a read phase, the shift clock pauses at a frame boundary, so no byte is invented or lost. A status register reports the busy flag, the fill level of both FIFOs and a transmit-empty flag. A control register holds self-clearing flush bits for each FIFO and a bit that resets the whole controller.

Top module: `spi_xfer_sequencer`

## Requirements
- R1: After reset, spi_cs_n is 1 and spi_sclk is 0. The status register reads 32'h0040_0000, and the timing register reads the parameter DIV_INIT.
- R2: The register map uses these word addresses: 0 control, 1 timing, 2 transfer, 3 data, 4 status. Writing the data register pushes bits 7:0 into the transmit FIFO, and the push is dropped when that FIFO is full. Reading the data register returns the head of the receive FIFO in bits 7:0 and pops it. The status fields are: bit 0 busy, bits 12:8 receive entries, bits 20:16 transmit entries, bit 22 transmit FIFO empty.
- R3: A write to the transfer register while the block is idle stores the value and starts a transfer. The fields are: mode in bits 27:24, write frames minus one in bits 20:12, read frames minus one in bits 8:0. A write there while busy is ignored, and the register keeps its old value.
- R4: Timing register bits 7:0 hold div. While CS is active, SCLK rests low, and each high or low half-period inside a frame lasts div+1 clock cycles.
- R5: MOSI carries the MSB first and changes only while SCLK is low, on the falling edge. MISO is sampled on each rising edge.
- R6: The mode selects the phase order. 0: simultaneous write and read, write-count frames, each received byte kept. 1: write. 2: read. 3: write then read. 4: read then write. 5: write, dummy, read. 6: read, dummy, write. 7: no frames. 8: dummy then write. 9: dummy then read. Codes 10 to 15 behave as 7.
- R7: A dummy phase is exactly one frame. MOSI is 0 throughout it, and the bits sampled on MISO are not stored. Pure write frames also store nothing, and pure read frames send 0.
- R8: CS falls div+2 clock cycles before the first rising SCLK edge. It rises div+2 cycles after the last falling edge. SCLK is never high while CS is inactive. In modes without frames, CS still pulses low.
- R9: In a write phase with the transmit FIFO empty, SCLK holds low at the frame boundary until a byte is pushed.
- R10: In a read phase with the receive FIFO full, SCLK holds low at the frame boundary until software pops an entry.
- R11: Writing the control register pulses its bits for one cycle and then clears them. Bit 2 empties the transmit FIFO, and bit 1 empties the receive FIFO. Bit 0 aborts any transfer, releases CS and empties both FIFOs.
- R12: The busy bit is 1 from the accepted transfer-register write until CS is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive FIFO at the data address) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The assertions assume the register port follows the rules: a pulse on reg_wr or reg_rd lasts exactly one clock, the divider is not changed while a transfer is running, and MISO changes only while SCLK is low. The bench keeps to these rules. It drives the register port only at falling clock edges, in single-cycle tasks, and rewrites the divider only while the block is idle. Its slave model updates MISO on the falling SCLK edge and when CS falls.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

    localparam int FRAME_W = 8;
    localparam int BIT_W   = $clog2(FRAME_W);
    localparam int CNT_W   = 9;
    localparam int ADDR_W  = 3;
    localparam int CTRL_W  = 3;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_TIMING = 3'd1;
    localparam logic [ADDR_W-1:0] A_XFER   = 3'd2;
    localparam logic [ADDR_W-1:0] A_DATA   = 3'd3;
    localparam logic [ADDR_W-1:0] A_STATUS = 3'd4;

    typedef enum logic [2:0] {PH_NONE, PH_BOTH, PH_WR, PH_RD, PH_DUMMY} phase_e;
    typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_SHIFT, ST_HOLD} seq_state_e;

    typedef struct packed {
        logic [3:0]       mode;
        logic [CNT_W-1:0] wcnt;
        logic [CNT_W-1:0] rcnt;
    } xfer_cfg_t;

    // Phase at position idx of the ordering picked by mode
    function automatic phase_e phase_of(input logic [3:0] mode, input logic [1:0] idx);
        phase_e p [3];
        p = '{PH_NONE, PH_NONE, PH_NONE};
        case (mode)
            4'd0: p[0] = PH_BOTH;
            4'd1: p[0] = PH_WR;
            4'd2: p[0] = PH_RD;
            4'd3: begin p[0] = PH_WR;    p[1] = PH_RD; end
            4'd4: begin p[0] = PH_RD;    p[1] = PH_WR; end
            4'd5: begin p[0] = PH_WR;    p[1] = PH_DUMMY; p[2] = PH_RD; end
            4'd6: begin p[0] = PH_RD;    p[1] = PH_DUMMY; p[2] = PH_WR; end
            4'd8: begin p[0] = PH_DUMMY; p[1] = PH_WR; end
            4'd9: begin p[0] = PH_DUMMY; p[1] = PH_RD; end
            default: ;
        endcase
        return (idx == 2'd3) ? PH_NONE : p[idx];
    endfunction

    // Frames in a phase, minus one
    function automatic logic [CNT_W-1:0] frames_m1(input phase_e ph, input xfer_cfg_t c);
        case (ph)
            PH_BOTH, PH_WR: return c.wcnt;
            PH_RD:          return c.rcnt;
            default:        return '0;
        endcase
    endfunction

endpackage

// File: rtl/spi_fifo.sv
module spi_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) begin
                mem[wp] <= din;
                wp      <= wp + 1'b1;
            end
            if (do_pop) rp <= rp + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    // A push into a full FIFO without a pop leaves the fill level unchanged
    assert_drop_when_full_R2: assert property (@(posedge clk) disable iff (rst || clr)
        (push && full && !pop) |=> (count == $past(count)));

endmodule

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/spi_seq_core.sv
module spi_seq_core
    import spi_seq_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  xfer_cfg_t          cfg,
    input  logic [DIV_W-1:0]   div,
    input  logic               tx_empty,
    input  logic [FRAME_W-1:0] tx_data,
    input  logic               rx_full,
    input  logic               miso,
    output logic               tx_pop,
    output logic               rx_push,
    output logic [FRAME_W-1:0] rx_data,
    output logic               busy,
    output logic               cs_n,
    output logic               sclk,
    output logic               mosi
);
    seq_state_e         state;
    logic [1:0]         ph_idx;
    logic [CNT_W-1:0]   left;
    logic [FRAME_W-1:0] tx_sh, rx_sh;
    logic [BIT_W-1:0]   bitn;
    phase_e             cur;
    logic               tick, need_tx, need_rx, can_go, frame_end;

    assign cur       = phase_of(cfg.mode, ph_idx);
    assign need_tx   = (cur == PH_BOTH) || (cur == PH_WR);
    assign need_rx   = (cur == PH_BOTH) || (cur == PH_RD);
    assign can_go    = !(need_tx && tx_empty) && !(need_rx && rx_full);
    assign tx_pop    = (state == ST_LOAD) && need_tx && can_go;
    assign frame_end = (state == ST_SHIFT) && tick && sclk && (bitn == BIT_W'(FRAME_W - 1));
    assign rx_push   = frame_end && need_rx;
    assign rx_data   = rx_sh;
    assign busy      = (state != ST_IDLE);
    assign mosi      = (state == ST_SHIFT) ? tx_sh[FRAME_W-1] : 1'b0;

    spi_half_tick #(.DIV_W(DIV_W)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  ((state == ST_SHIFT) || (state == ST_HOLD)),
        .div  (div),
        .tick (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            ph_idx <= '0;
            left   <= '0;
            tx_sh  <= '0;
            rx_sh  <= '0;
            bitn   <= '0;
            cs_n   <= 1'b1;
            sclk   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    ph_idx <= '0;
                    left   <= frames_m1(phase_of(cfg.mode, 2'd0), cfg);
                    cs_n   <= 1'b0;
                    state  <= ST_LOAD;
                end
                ST_LOAD: begin
                    if (cur == PH_NONE) begin
                        state <= ST_HOLD;
                    end else if (can_go) begin
                        tx_sh <= need_tx ? tx_data : '0;
                        bitn  <= '0;
                        state <= ST_SHIFT;
                    end
                end
                ST_SHIFT: if (tick) begin
                    sclk <= ~sclk;
                    if (!sclk) begin
                        rx_sh <= {rx_sh[FRAME_W-2:0], miso};
                    end else begin
                        tx_sh <= tx_sh << 1;
                        bitn  <= bitn + 1'b1;
                        if (frame_end) begin
                            state <= ST_LOAD;
                            if (left == '0) begin
                                ph_idx <= ph_idx + 2'd1;
                                left   <= frames_m1(phase_of(cfg.mode, ph_idx + 2'd1), cfg);
                            end else begin
                                left <= left - 1'b1;
                            end
                        end
                    end
                end
                ST_HOLD: if (tick) begin
                    cs_n  <= 1'b1;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_sclk_inside_cs_R8: assert property (@(posedge clk) disable iff (rst)
        sclk |-> !cs_n);
    assert_mosi_steady_high_R5: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(mosi));
    assert_pop_has_data_R9: assert property (@(posedge clk) disable iff (rst)
        tx_pop |-> !tx_empty);
    assert_push_has_room_R10: assert property (@(posedge clk) disable iff (rst)
        rx_push |-> !rx_full);
    assert_dummy_mosi_low_R7: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_SHIFT) && (cur == PH_DUMMY)) |-> !mosi);
    assert_idle_cs_high_R12: assert property (@(posedge clk) disable iff (rst)
        !busy |-> cs_n);

endmodule

// File: rtl/spi_xfer_sequencer.sv
module spi_xfer_sequencer
    import spi_seq_pkg::*;
#(
    parameter int              TX_DEPTH = 4,
    parameter int              RX_DEPTH = 4,
    parameter int              DIV_W    = 8,
    parameter logic [DIV_W-1:0] DIV_INIT = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        spi_cs_n,
    output logic        spi_sclk,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    localparam int TCW = $clog2(TX_DEPTH + 1);
    localparam int RCW = $clog2(RX_DEPTH + 1);

    logic [CTRL_W-1:0]  ctrl_q;
    logic [DIV_W-1:0]   div_q;
    logic [31:0]        xfer_q;
    logic               start_q, seq_busy, busy, soft_rst;
    logic               tx_pop, tx_empty, tx_full, rx_push, rx_empty, rx_full;
    logic [FRAME_W-1:0] tx_dout, rx_din, rx_dout;
    logic [TCW-1:0]     tx_cnt;
    logic [RCW-1:0]     rx_cnt;
    xfer_cfg_t          cfg;

    assign soft_rst = rst || ctrl_q[0];
    assign busy     = seq_busy || start_q;
    assign cfg      = '{mode: xfer_q[27:24], wcnt: xfer_q[20:12], rcnt: xfer_q[8:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            div_q   <= DIV_INIT;
            xfer_q  <= '0;
            start_q <= 1'b0;
        end else begin
            ctrl_q  <= (reg_wr && reg_addr == A_CTRL) ? reg_wdata[CTRL_W-1:0] : '0;
            start_q <= 1'b0;
            if (reg_wr && reg_addr == A_TIMING) div_q <= reg_wdata[DIV_W-1:0];
            if (ctrl_q[0]) begin
                start_q <= 1'b0;
            end else if (reg_wr && reg_addr == A_XFER && !busy) begin
                xfer_q  <= reg_wdata;
                start_q <= 1'b1;
            end
        end
    end

    spi_fifo #(.W(FRAME_W), .DEPTH(TX_DEPTH)) u_txq (
        .clk   (clk),
        .rst   (rst),
        .clr   (ctrl_q[2] || ctrl_q[0]),
        .push  (reg_wr && reg_addr == A_DATA),
        .din   (reg_wdata[FRAME_W-1:0]),
        .pop   (tx_pop),
        .dout  (tx_dout),
        .count (tx_cnt),
        .empty (tx_empty),
        .full  (tx_full)
    );

    spi_fifo #(.W(FRAME_W), .DEPTH(RX_DEPTH)) u_rxq (
        .clk   (clk),
        .rst   (rst),
        .clr   (ctrl_q[1] || ctrl_q[0]),
        .push  (rx_push),
        .din   (rx_din),
        .pop   (reg_rd && reg_addr == A_DATA),
        .dout  (rx_dout),
        .count (rx_cnt),
        .empty (rx_empty),
        .full  (rx_full)
    );

    spi_seq_core #(.DIV_W(DIV_W)) u_core (
        .clk      (clk),
        .rst      (soft_rst),
        .start    (start_q),
        .cfg      (cfg),
        .div      (div_q),
        .tx_empty (tx_empty),
        .tx_data  (tx_dout),
        .rx_full  (rx_full),
        .miso     (spi_miso),
        .tx_pop   (tx_pop),
        .rx_push  (rx_push),
        .rx_data  (rx_din),
        .busy     (seq_busy),
        .cs_n     (spi_cs_n),
        .sclk     (spi_sclk),
        .mosi     (spi_mosi)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL:   reg_rdata[CTRL_W-1:0]  = ctrl_q;
            A_TIMING: reg_rdata[DIV_W-1:0]   = div_q;
            A_XFER:   reg_rdata              = xfer_q;
            A_DATA:   reg_rdata[FRAME_W-1:0] = rx_dout;
            A_STATUS: begin
                reg_rdata[0]     = busy;
                reg_rdata[12:8]  = 5'(rx_cnt);
                reg_rdata[20:16] = 5'(tx_cnt);
                reg_rdata[22]    = tx_empty;
            end
            default: ;
        endcase
    end

    assert_ctrl_selfclear_R11: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_addr == A_CTRL) |=> (ctrl_q == '0));
    assert_tx_flush_R11: assert property (@(posedge clk) disable iff (rst)
        ctrl_q[2] |=> (tx_cnt == '0));
    assert_busy_ignores_xfer_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && !ctrl_q[0]) |=> $stable(xfer_q));
    assert_empty_flag_R2: assert property (@(posedge clk) disable iff (rst)
        (tx_empty && !tx_full) || !tx_empty);

endmodule

// File: tb/spi_xfer_sequencer_bench.sv
`timescale 1ns/100ps
module spi_xfer_sequencer_bench;

    localparam logic [2:0] AD_CTRL = 3'd0, AD_TIM = 3'd1, AD_XFER = 3'd2, AD_DATA = 3'd3, AD_STAT = 3'd4;
    localparam int K_NONE = 0, K_BOTH = 1, K_WR = 2, K_RD = 3, K_DUM = 4;
    localparam int NV = 11;
    // {mode, write frames, read frames}
    localparam logic [11:0] VEC [NV] = '{
        {4'd0, 4'd3, 4'd1}, {4'd1, 4'd4, 4'd0}, {4'd2, 4'd0, 4'd3}, {4'd3, 4'd2, 4'd2},
        {4'd4, 4'd2, 4'd2}, {4'd5, 4'd1, 4'd3}, {4'd6, 4'd3, 4'd2}, {4'd7, 4'd0, 4'd0},
        {4'd8, 4'd2, 4'd0}, {4'd9, 4'd0, 4'd1}, {4'd12, 4'd2, 4'd2}
    };

    logic        clk = 1'b0, rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        spi_cs_n, spi_sclk, spi_mosi;
    logic        spi_miso = 1'b0;

    int total = 0, bad = 0;
    int cyc = 0, hi_clks = 0, nrise = 0, fidx = 0, bitpos = 0;
    int t_csfall = 0, t_csrise = 0, t_rise1 = 0, t_fall = 0;
    logic [7:0] sh = '0;
    logic [7:0] mosi_log [32];
    logic [31:0] rv;

    spi_xfer_sequencer u_spi_xfer_sequencer (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_cs_n(spi_cs_n),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    always #2.5 clk = ~clk;

    function automatic logic [7:0] resp(input int k);
        return 8'(8'hC3 + k * 29);
    endfunction

    function automatic logic [7:0] wd(input int v, input int i);
        return 8'(8'h5A + v * 19 + i * 39);
    endfunction

    function automatic int bph(input int mode, input int idx);
        int p [3];
        p = '{K_NONE, K_NONE, K_NONE};
        case (mode)
            0: p[0] = K_BOTH;
            1: p[0] = K_WR;
            2: p[0] = K_RD;
            3: p = '{K_WR, K_RD, K_NONE};
            4: p = '{K_RD, K_WR, K_NONE};
            5: p = '{K_WR, K_DUM, K_RD};
            6: p = '{K_RD, K_DUM, K_WR};
            8: p = '{K_DUM, K_WR, K_NONE};
            9: p = '{K_DUM, K_RD, K_NONE};
            default: ;
        endcase
        return p[idx];
    endfunction

    // Clock-cycle counter and SCLK-high counter
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (spi_sclk) hi_clks = hi_clks + 1;
    end

    // SPI slave model
    always @(negedge spi_cs_n) begin
        bitpos = 0; fidx = 0; t_csfall = cyc; spi_miso = resp(0)[7];
    end
    always @(posedge spi_cs_n) t_csrise = cyc;
    always @(posedge spi_sclk) begin
        if (nrise == 0) t_rise1 = cyc;
        nrise = nrise + 1;
        sh = {sh[6:0], spi_mosi};
        bitpos = bitpos + 1;
        if (bitpos == 8) begin
            if (fidx < 32) mosi_log[fidx] = sh;
            fidx = fidx + 1;
            bitpos = 0;
        end
    end
    always @(negedge spi_sclk) begin
        t_fall = cyc;
        spi_miso = resp(fidx)[7 - bitpos];
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 20000; i++) begin
            rd(AD_STAT, s);
            if (!s[0]) break;
        end
    endtask

    function automatic logic [31:0] xfer_word(input int mode, input int nw, input int nr);
        return {4'h0, 4'(mode), 3'b0, 9'(nw - 1), 3'b0, 9'(nr - 1)};
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        #1;
        chk("R1 cs_n", 32'(spi_cs_n), 32'd1);
        chk("R1 sclk", 32'(spi_sclk), 32'd0);
        rd(AD_STAT, rv); chk("R1 status", rv, 32'h0040_0000);
        rd(AD_TIM, rv);  chk("R1 timing", rv, 32'd3);

        // R4 R8 half-period and CS lead/lag with div=2
        wr(AD_TIM, 32'd2);
        wr(AD_DATA, 32'h96);
        rd(AD_STAT, rv); chk("R2 tx count", 32'(rv[20:16]), 32'd1);
        chk("R2 tx empty", 32'(rv[22]), 32'd0);
        nrise = 0; hi_clks = 0;
        wr(AD_XFER, xfer_word(1, 1, 1));
        wait_idle();
        chk("R4 sclk high clocks", 32'(hi_clks), 32'd24);
        chk("R8 cs lead", 32'(t_rise1 - t_csfall), 32'd4);
        chk("R8 cs lag", 32'(t_csrise - t_fall), 32'd4);
        chk("R5 msb first byte", 32'(mosi_log[0]), 32'h96);

        // R6 R7 phase orderings, table driven
        wr(AD_TIM, 32'd1);
        for (int v = 0; v < NV; v++) begin
            int mode, nw, nr, nfr, nrx, wi;
            logic [7:0] exp_mosi [16];
            logic [7:0] exp_rx [16];
            mode = int'(VEC[v][11:8]); nw = int'(VEC[v][7:4]); nr = int'(VEC[v][3:0]);
            nfr = 0; nrx = 0; wi = 0;
            for (int p = 0; p < 3; p++) begin
                int k, n;
                k = bph(mode, p);
                n = (k == K_BOTH || k == K_WR) ? nw : (k == K_RD) ? nr : (k == K_DUM) ? 1 : 0;
                for (int f = 0; f < n; f++) begin
                    exp_mosi[nfr] = (k == K_BOTH || k == K_WR) ? wd(v, wi) : 8'h00;
                    if (k == K_BOTH || k == K_WR) wi++;
                    if (k == K_BOTH || k == K_RD) begin exp_rx[nrx] = resp(nfr); nrx++; end
                    nfr++;
                end
            end
            for (int i = 0; i < wi; i++) wr(AD_DATA, 32'(wd(v, i)));
            nrise = 0;
            wr(AD_XFER, xfer_word(mode, nw, nr));
            wait_idle();
            chk($sformatf("R6 mode %0d rising edges", mode), 32'(nrise), 32'(8 * nfr));
            for (int f = 0; f < nfr; f++)
                chk($sformatf("R7 mode %0d mosi frame %0d", mode, f), 32'(mosi_log[f]), 32'(exp_mosi[f]));
            rd(AD_STAT, rv);
            chk($sformatf("R6 mode %0d rx count", mode), 32'(rv[12:8]), 32'(nrx));
            chk($sformatf("R6 mode %0d tx drained", mode), 32'(rv[22]), 32'd1);
            for (int i = 0; i < nrx; i++) begin
                rd(AD_DATA, rv);
                chk($sformatf("R6 mode %0d rx byte %0d", mode, i), 32'(rv[7:0]), 32'(exp_rx[i]));
            end
        end

        // R12 busy and CS pulse in the no-data mode
        nrise = 0;
        wr(AD_XFER, xfer_word(7, 1, 1));
        rd(AD_STAT, rv); chk("R12 busy after start", 32'(rv[0]), 32'd1);
        chk("R12 cs low while busy", 32'(spi_cs_n), 32'd0);
        wait_idle();
        chk("R12 cs released", 32'(spi_cs_n), 32'd1);
        chk("R8 no edges in mode 7", 32'(nrise), 32'd0);

        // R9 TX empty stall; R3 write while busy ignored
        nrise = 0;
        wr(AD_XFER, xfer_word(1, 2, 1));
        repeat (30) @(negedge clk);
        chk("R9 stalled no edges", 32'(nrise), 32'd0);
        rd(AD_STAT, rv); chk("R9 busy while stalled", 32'(rv[0]), 32'd1);
        wr(AD_XFER, xfer_word(2, 1, 3));
        rd(AD_XFER, rv); chk("R3 xfer kept while busy", rv, xfer_word(1, 2, 1));
        wr(AD_DATA, 32'hE1);
        repeat (60) @(negedge clk);
        chk("R9 one frame then stall", 32'(nrise), 32'd8);
        wr(AD_DATA, 32'h1E);
        wait_idle();
        chk("R9 both frames", 32'(nrise), 32'd16);
        chk("R9 frame 1 data", 32'(mosi_log[1]), 32'h1E);
        rd(AD_STAT, rv); chk("R3 ignored read mode left no rx", 32'(rv[12:8]), 32'd0);

        // R10 RX full stall
        nrise = 0;
        wr(AD_XFER, xfer_word(2, 1, 6));
        repeat (400) @(negedge clk);
        chk("R10 stalled after four frames", 32'(nrise), 32'd32);
        rd(AD_STAT, rv);
        chk("R10 busy while full", 32'(rv[0]), 32'd1);
        chk("R10 rx full count", 32'(rv[12:8]), 32'd4);
        for (int i = 0; i < 2; i++) begin
            rd(AD_DATA, rv); chk("R10 early byte", 32'(rv[7:0]), 32'(resp(i)));
        end
        wait_idle();
        chk("R10 all frames", 32'(nrise), 32'd48);
        for (int i = 2; i < 6; i++) begin
            rd(AD_DATA, rv); chk("R10 late byte", 32'(rv[7:0]), 32'(resp(i)));
        end

        // R11 flush bits
        wr(AD_XFER, xfer_word(2, 1, 2));
        wait_idle();
        wr(AD_DATA, 32'h44);
        wr(AD_CTRL, 32'd2);
        rd(AD_STAT, rv);
        chk("R11 rx flushed", 32'(rv[12:8]), 32'd0);
        chk("R11 tx kept on rx flush", 32'(rv[20:16]), 32'd1);
        rd(AD_CTRL, rv); chk("R11 ctrl self clear", rv, 32'd0);
        wr(AD_DATA, 32'h45);
        wr(AD_CTRL, 32'd4);
        rd(AD_STAT, rv);
        chk("R11 tx flushed", 32'(rv[20:16]), 32'd0);
        chk("R11 tx empty after flush", 32'(rv[22]), 32'd1);

        // R11 controller reset aborts a transfer
        wr(AD_XFER, xfer_word(2, 1, 4));
        repeat (12) @(negedge clk);
        wr(AD_CTRL, 32'd1);
        repeat (2) @(negedge clk);
        chk("R11 abort cs high", 32'(spi_cs_n), 32'd1);
        chk("R11 abort sclk low", 32'(spi_sclk), 32'd0);
        rd(AD_STAT, rv);
        chk("R11 abort status", rv, 32'h0040_0000);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule